// File: doc/BRIEF.md
# Half-Bridge Deadtime and Interlock Controller

This block is the clocked control core of a half-bridge gate driver. It takes two command inputs, a high-side command that is active high and a low-side command that is active low, and produces two gate-enable outputs. The outputs are never on together. Whenever one output goes off, the other one must wait for a minimum deadtime before it may turn on. If the commands already leave a wider gap, that gap passes through unchanged.

The outputs are also gated by three synchronous flags. A logic-supply undervoltage flag turns both sides off. A floating-supply undervoltage flag turns only the high side off. A negative switch-node transient flag starts a long hold-off of the high side, but only if the flag stays set longer than a qualification time. Every input passes through a synchronizer. All times are parameters counted in clock cycles: `DEAD_CYC`, `QUAL_CYC`, `HOLD_CYC` and `SYNC_STAGES`. The defaults of 53, 5, 450 and 2 suit a 100 MHz clock.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `hi_gate` follows `hi_cmd` in phase. `lo_gate` is on while `lo_cmd_n` is low. With `SYNC_STAGES`=2, a command change reaches its output on the third rising edge after it is applied. The latency is the same for both sides and for turn-on and turn-off.
- R2: While both commands request conduction (`hi_cmd`=1 and `lo_cmd_n`=0), both outputs are held off.
- R3: `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R4: After either output goes off, the opposite output turns on only after both outputs have been off for at least `DEAD_CYC` cycles. This holds for both directions and also after a lockout clears.
- R5: If the commands leave a gap of g cycles between one side's turn-off command and the other side's turn-on command, the gap at the outputs is max(g, `DEAD_CYC`) cycles.
- R6: `logic_uv`=1 forces both outputs off.
- R7: `float_uv`=1 forces `hi_gate` off and leaves `lo_gate` unaffected. Once it clears, a pending high-side request turns on with the normal R1 latency, provided the deadtime is already met.
- R8: During reset both outputs are 0. After reset, the synchronized undervoltage flags start in the undervoltage state. No output turns on until `logic_uv` has been sampled low.
- R9: If `neg_tran` is high for more than `QUAL_CYC` consecutive cycles, `hi_gate` is held off for exactly `HOLD_CYC` cycles. The hold-off does not restart while the flag stays high. A pulse of `QUAL_CYC` cycles or fewer has no effect. `lo_gate` is never affected by this flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | High-side command, 1 requests conduction |
| lo_cmd_n | input | 1 | Low-side command, 0 requests conduction |
| logic_uv | input | 1 | Logic-supply undervoltage flag, 1 means undervoltage |
| float_uv | input | 1 | Floating-supply undervoltage flag, 1 means undervoltage |
| neg_tran | input | 1 | Negative switch-node transient flag |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |

## Verification
The interesting coincidence is a deadtime expiry landing in the same cycle as a fresh command edge on the opposite side. The bench provokes it by sweeping the commanded gap from zero to a few cycles past the deadtime, in both directions. At each step it compares the measured off-gap with max(g, `DEAD_CYC`). A second coincidence is a transient hold-off that starts while the high side is conducting. The bench judges it by counting the high side's off cycles against `HOLD_CYC` for pulses just below, at and well above the qualification length, while the low side is checked to stay untouched.

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int DEAD_CYC    = 53,
  parameter int QUAL_CYC    = 5,
  parameter int HOLD_CYC    = 450,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd_n,
  input  logic logic_uv,
  input  logic float_uv,
  input  logic neg_tran,
  output logic hi_gate,
  output logic lo_gate
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 2);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYC - 1);
  localparam logic [QW-1:0] QUAL_HIT  = QW'(QUAL_CYC);
  localparam logic [QW-1:0] QUAL_SAT  = QW'(QUAL_CYC + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);
  localparam logic [4:0]    SYNC_RST  = 5'b01100;

  logic [4:0] sync_q [SYNC_STAGES];
  logic [4:0] s;
  logic [QW-1:0] run_cnt;
  logic [HW-1:0] hold_cnt;
  logic [DW-1:0] hi_idle, lo_idle;
  logic trig, req_hi, req_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
    end else begin
      sync_q[0] <= {neg_tran, float_uv, logic_uv, ~lo_cmd_n, hi_cmd};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC_STAGES-1];

  assign trig = s[4] && (run_cnt == QUAL_HIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      hold_cnt <= '0;
    end else begin
      if (!s[4])                  run_cnt <= '0;
      else if (run_cnt != QUAL_SAT) run_cnt <= run_cnt + 1'b1;
      if (trig)                   hold_cnt <= HOLD_LOAD;
      else if (hold_cnt != '0)    hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign req_hi = s[0] & ~s[1] & ~s[2] & ~s[3] & (hold_cnt == '0);
  assign req_lo = s[1] & ~s[0] & ~s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_idle <= '0;
      lo_idle <= '0;
      hi_gate <= 1'b0;
      lo_gate <= 1'b0;
    end else begin
      if (hi_gate)                  hi_idle <= '0;
      else if (hi_idle != DEAD_LAST) hi_idle <= hi_idle + 1'b1;
      if (lo_gate)                  lo_idle <= '0;
      else if (lo_idle != DEAD_LAST) lo_idle <= lo_idle + 1'b1;
      hi_gate <= req_hi & ~lo_gate & (lo_idle == DEAD_LAST);
      lo_gate <= req_lo & ~hi_gate & (hi_idle == DEAD_LAST);
    end
  end
endmodule

module hb_deadtime_chk #(
  parameter int DEAD_CYC    = 53,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic logic_uv,
  input logic float_uv,
  input logic hi_gate,
  input logic lo_gate
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam int RW = $clog2(SYNC_STAGES + 1);
  localparam logic [CW-1:0] CDEAD = CW'(DEAD_CYC);
  localparam logic [RW-1:0] RSAT  = RW'(SYNC_STAGES);

  logic [CW-1:0] hi_off_run, lo_off_run;
  logic [RW-1:0] luv_run, fuv_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_off_run <= '0;
      lo_off_run <= '0;
      luv_run    <= '0;
      fuv_run    <= '0;
    end else begin
      hi_off_run <= hi_gate ? '0 : (hi_off_run == CDEAD ? hi_off_run : hi_off_run + 1'b1);
      lo_off_run <= lo_gate ? '0 : (lo_off_run == CDEAD ? lo_off_run : lo_off_run + 1'b1);
      luv_run    <= !logic_uv ? '0 : (luv_run == RSAT ? luv_run : luv_run + 1'b1);
      fuv_run    <= !float_uv ? '0 : (fuv_run == RSAT ? fuv_run : fuv_run + 1'b1);
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));
  assert_hi_deadtime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> lo_off_run >= CDEAD);
  assert_lo_deadtime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate) |-> hi_off_run >= CDEAD);
  assert_logic_uv_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_uv && luv_run >= RSAT) |=> (!hi_gate && !lo_gate));
  assert_float_uv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (float_uv && fuv_run >= RSAT) |=> !hi_gate);
endmodule

bind hb_deadtime_ctrl hb_deadtime_chk #(.DEAD_CYC(DEAD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .logic_uv(logic_uv), .float_uv(float_uv),
  .hi_gate(hi_gate), .lo_gate(lo_gate)
);

// File: tb/hb_deadtime_ctrl_test.sv
module hb_deadtime_ctrl_test;
  localparam int DEAD = 4;
  localparam int QUAL = 2;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_cmd = 1'b0, lo_cmd_n = 1'b1, logic_uv = 1'b1, float_uv = 1'b1, neg_tran = 1'b0;
  logic hi_gate, lo_gate;
  int compared = 0, mismatched = 0, overlap = 0;

  always #2 clk = ~clk;

  hb_deadtime_ctrl #(.DEAD_CYC(DEAD), .QUAL_CYC(QUAL), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n), .logic_uv(logic_uv),
    .float_uv(float_uv), .neg_tran(neg_tran), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  always @(negedge clk) if (rst_n && hi_gate && lo_gate) overlap++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic gap_lo_to_hi(input int g);
    int cnt = 0;
    hi_cmd = 0; lo_cmd_n = 0; tick(15);
    fork
      begin lo_cmd_n = 1; tick(g); hi_cmd = 1; end
      begin
        for (int k = 0; k < 60 && lo_gate; k++) @(negedge clk);
        while (!hi_gate && cnt < 100) begin cnt++; @(negedge clk); end
      end
    join
    chk($sformatf("R5 R4 lo->hi gap g=%0d", g), cnt, (g > DEAD) ? g : DEAD);
  endtask

  task automatic gap_hi_to_lo(input int g);
    int cnt = 0;
    hi_cmd = 1; lo_cmd_n = 1; tick(15);
    fork
      begin hi_cmd = 0; tick(g); lo_cmd_n = 0; end
      begin
        for (int k = 0; k < 60 && hi_gate; k++) @(negedge clk);
        while (!lo_gate && cnt < 100) begin cnt++; @(negedge clk); end
      end
    join
    chk($sformatf("R5 R4 hi->lo gap g=%0d", g), cnt, (g > DEAD) ? g : DEAD);
  endtask

  task automatic tran_pulse(input int p, input bit watch_hi, input int exp_off);
    int off = 0;
    fork
      begin neg_tran = 1; tick(p); neg_tran = 0; end
      begin
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          if (watch_hi ? !hi_gate : !lo_gate) off++;
        end
      end
    join
    chk($sformatf("R9 transient p=%0d side=%s off cycles", p, watch_hi ? "hi" : "lo"), off, exp_off);
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    chk("R8 reset hi_gate", hi_gate, 0);
    chk("R8 reset lo_gate", lo_gate, 0);
    hi_cmd = 1; lo_cmd_n = 1;
    rst_n = 1;
    tick(20);
    chk("R8 held by logic_uv hi_gate", hi_gate, 0);
    logic_uv = 0; float_uv = 0;
    tick(20);
    chk("R1 high side in phase", hi_gate, 1);
    chk("R1 low side off", lo_gate, 0);

    hi_cmd = 0;
    tick(2); chk("R1 hi turn-off latency early", hi_gate, 1);
    tick(1); chk("R1 hi turn-off latency", hi_gate, 0);
    tick(10);
    lo_cmd_n = 0;
    tick(2); chk("R1 lo turn-on latency early", lo_gate, 0);
    tick(1); chk("R1 lo turn-on latency inverted", lo_gate, 1);
    lo_cmd_n = 1;
    tick(2); chk("R1 lo turn-off latency early", lo_gate, 1);
    tick(1); chk("R1 lo turn-off latency", lo_gate, 0);
    tick(10);
    hi_cmd = 1;
    tick(2); chk("R1 hi turn-on latency early", hi_gate, 0);
    tick(1); chk("R1 hi turn-on latency", hi_gate, 1);

    for (int g = 0; g <= DEAD + 3; g++) gap_lo_to_hi(g);
    for (int g = 0; g <= DEAD + 3; g++) gap_hi_to_lo(g);

    hi_cmd = 1; lo_cmd_n = 0; tick(15);
    chk("R2 both requested hi", hi_gate, 0);
    chk("R2 both requested lo", lo_gate, 0);
    hi_cmd = 0; tick(15);
    chk("R2 lo alone", lo_gate, 1);
    hi_cmd = 1; tick(15);
    chk("R2 from lo on hi", hi_gate, 0);
    chk("R2 from lo on lo", lo_gate, 0);

    hi_cmd = 1; lo_cmd_n = 1; tick(15);
    logic_uv = 1; tick(4);
    chk("R6 logic_uv hi off", hi_gate, 0);
    hi_cmd = 0; lo_cmd_n = 0; tick(15);
    chk("R6 logic_uv lo blocked", lo_gate, 0);
    logic_uv = 0; tick(15);
    chk("R6 lo after clear", lo_gate, 1);
    logic_uv = 1; tick(4);
    chk("R6 logic_uv lo off", lo_gate, 0);
    logic_uv = 0; tick(15);

    float_uv = 1; tick(15);
    chk("R7 float_uv lo unaffected", lo_gate, 1);
    hi_cmd = 1; lo_cmd_n = 1; tick(15);
    chk("R7 float_uv hi blocked", hi_gate, 0);
    float_uv = 0;
    tick(2); chk("R7 hi after clear early", hi_gate, 0);
    tick(1); chk("R7 hi after clear latency", hi_gate, 1);

    tick(10);
    tran_pulse(QUAL, 1'b1, 0);
    tick(20);
    tran_pulse(QUAL + 1, 1'b1, HOLD);
    tick(20);
    tran_pulse(QUAL + 8, 1'b1, HOLD);
    tick(20);
    hi_cmd = 0; lo_cmd_n = 0; tick(15);
    tran_pulse(QUAL + 4, 1'b0, 0);

    chk("R3 overlap cycles", overlap, 0);
    summary();
    $finish;
  end
endmodule